// File: doc/BRIEF.md
# Program Counter with Vectored Start-Up

This block holds the program counter for a core whose instructions are all two bytes long. On a power-on reset it sets its vector-table base register to 0x00C00000. It reads the start address from the reset entry of that table through a synchronous read port. It loads that address into the PC with bit 0 cleared, then raises a flag that lets instruction fetch begin.

While running, the PC either holds because of a stall, jumps to a branch target with bit 0 cleared, or steps forward by one instruction. The datapath sees the PC through a read-only output. That output carries the address of the issuing instruction plus 2, which is the value an instruction that copies the PC into a general register writes.

A special-register write port has a one-bit target select. Select 0 loads the table base, with its two low bits forced to zero. Select 1 names the PC, and such writes are discarded. A warm reset keeps the table base and runs the vector fetch again.

Top module: `pc_unit`

## Requirements
- R1: While `por_n` is low, the table base returns to 0x00C00000, `vec_rd_en_o` is 1, `vec_rd_addr_o` is 0x00C00000 and `run_ready_o` is 0.
- R2: After a reset is released, the first rising edge issues the vector read. The read data is sampled on the second edge. From then on `run_ready_o` is 1 and `pc_o` equals the read word with bit 0 cleared.
- R3: When running with no stall and no branch, `pc_o` advances by 2 each cycle, wrapping modulo 2^32.
- R4: When running with `br_take_i` high and no stall, `pc_o` takes `br_target_i` with bit 0 cleared on the next edge. A branch wins over the sequential step.
- R5: `stall_i` high while running keeps `pc_o` unchanged, even if a branch is also requested.
- R6: Once `run_ready_o` is 1, `pc_o[0]` is always 0.
- R7: `pc_read_o` equals `pc_o + 2` in every running cycle, stalled or not.
- R8: A write with `sr_wr_sel_i = 1` (PC target) has no effect on `pc_o`.
- R9: A write with `sr_wr_sel_i = 0` sets the table base to `sr_wr_data_i` with bits 1:0 cleared. The next vector read uses that address.
- R10: A warm reset (`rst_n` low, `por_n` high) keeps the table base and repeats the vector sequence of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold (power-on) reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| stall_i | input | 1 | Hold the PC this cycle |
| br_take_i | input | 1 | Take a branch this cycle |
| br_target_i | input | 32 | Branch destination |
| sr_wr_en_i | input | 1 | Special-register write strobe |
| sr_wr_sel_i | input | 1 | Write target: 0 table base, 1 PC (ignored) |
| sr_wr_data_i | input | 32 | Special-register write data |
| vec_rd_en_o | output | 1 | Vector read request |
| vec_rd_addr_o | output | 32 | Vector read address (table base + reset offset) |
| vec_rd_data_i | input | 32 | Vector read data, one cycle after the request edge |
| run_ready_o | output | 1 | Start-up done; fetch may proceed |
| pc_o | output | 32 | Address of the issuing instruction |
| pc_read_o | output | 32 | Value that software sees when it reads the PC |

## Verification
The assertions assume that the vector memory returns the addressed word exactly one clock after the edge that samples the request. They also assume that `por_n` is asserted on a clock edge before any run-time checks start. The bench memory model registers its output on each requested edge. All stimulus changes on the falling clock edge. `por_n` is driven low before the first rising edge, so both assumptions hold throughout the run.

// File: rtl/pc_unit_pkg.sv
`timescale 1ns/1ps
package pc_unit_pkg;

    // Start-up sequencer states
    typedef enum logic [1:0] {
        SEQ_FETCH = 2'd0,   // vector read request on the port
        SEQ_LOAD  = 2'd1,   // read word present, PC captures it
        SEQ_RUN   = 2'd2    // normal execution
    } seq_state_e;

    localparam logic SEL_TBASE = 1'b0;
    localparam logic SEL_PC    = 1'b1;

endpackage

// File: rtl/pc_tbase_reg.sv
`timescale 1ns/1ps
module pc_tbase_reg #(
    parameter int AW = 32,
    parameter int ALIGN = 2,
    parameter logic [AW-1:0] COLD_BASE = '0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_data_i,
    output logic [AW-1:0] base_o
);
    localparam logic [AW-1:0] KEEP_MASK = ~((AW'(1) << ALIGN) - AW'(1));

    typedef struct packed {
        logic [AW-1:0] base;
    } tb_regs_t;

    tb_regs_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (wr_en_i) begin
            tb_d.base = wr_data_i & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tb_q.base <= COLD_BASE & KEEP_MASK;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign base_o = tb_q.base;

endmodule

// File: rtl/pc_rst_seq.sv
`timescale 1ns/1ps
module pc_rst_seq
    import pc_unit_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] VEC_OFS = '0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          load_o,
    output logic          ready_o
);
    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_FETCH: seq_d.state = SEQ_LOAD;
            SEQ_LOAD:  seq_d.state = SEQ_RUN;
            SEQ_RUN:   seq_d.state = SEQ_RUN;
            default:   seq_d.state = SEQ_FETCH;
        endcase
        // warm reset restarts the vector fetch
        if (!rst_n) begin
            seq_d.state = SEQ_FETCH;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q.state <= SEQ_FETCH;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_en_o   = (seq_q.state == SEQ_FETCH);
    assign load_o    = (seq_q.state == SEQ_LOAD);
    assign ready_o   = (seq_q.state == SEQ_RUN);
    assign rd_addr_o = base_i + VEC_OFS;

endmodule

// File: rtl/pc_core_reg.sv
`timescale 1ns/1ps
module pc_core_reg #(
    parameter int AW = 32,
    parameter int INSN_BYTES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          load_i,
    input  logic [AW-1:0] vec_word_i,
    input  logic          adv_en_i,
    input  logic          stall_i,
    input  logic          br_take_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] pc_read_o
);
    localparam logic [AW-1:0] STEP       = AW'(INSN_BYTES);
    localparam logic [AW-1:0] ALIGN_MASK = ~(STEP - AW'(1));

    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_regs_t;

    pc_regs_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (load_i) begin
            pc_d.pc = vec_word_i & ALIGN_MASK;
        end else if (adv_en_i && !stall_i) begin
            if (br_take_i) begin
                pc_d.pc = br_target_i & ALIGN_MASK;
            end else begin
                pc_d.pc = pc_q.pc + STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pc_q.pc <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o      = pc_q.pc;
    assign pc_read_o = pc_q.pc + STEP;

endmodule

// File: rtl/pc_unit.sv
`timescale 1ns/1ps
module pc_unit
    import pc_unit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INSN_BYTES = 2,
    parameter int TBASE_ALIGN = 2,
    parameter logic [ADDR_W-1:0] COLD_TBASE = 32'h00C0_0000,
    parameter logic [ADDR_W-1:0] RST_VEC_OFS = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              br_take_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic              sr_wr_en_i,
    input  logic              sr_wr_sel_i,
    input  logic [ADDR_W-1:0] sr_wr_data_i,
    output logic              vec_rd_en_o,
    output logic [ADDR_W-1:0] vec_rd_addr_o,
    input  logic [ADDR_W-1:0] vec_rd_data_i,
    output logic              run_ready_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_read_o
);
    logic [ADDR_W-1:0] tbase;
    logic              tb_wr;
    logic              vec_load;
    logic              adv_en;

    // PC-targeted writes decode to nothing: the PC is read-only
    assign tb_wr  = sr_wr_en_i && (sr_wr_sel_i == SEL_TBASE);
    assign adv_en = run_ready_o && rst_n;

    pc_tbase_reg #(
        .AW        (ADDR_W),
        .ALIGN     (TBASE_ALIGN),
        .COLD_BASE (COLD_TBASE)
    ) tbase_i (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en_i   (tb_wr),
        .wr_data_i (sr_wr_data_i),
        .base_o    (tbase)
    );

    pc_rst_seq #(
        .AW      (ADDR_W),
        .VEC_OFS (RST_VEC_OFS)
    ) seq_i (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .base_i    (tbase),
        .rd_en_o   (vec_rd_en_o),
        .rd_addr_o (vec_rd_addr_o),
        .load_o    (vec_load),
        .ready_o   (run_ready_o)
    );

    pc_core_reg #(
        .AW         (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) core_i (
        .clk         (clk),
        .por_n       (por_n),
        .load_i      (vec_load),
        .vec_word_i  (vec_rd_data_i),
        .adv_en_i    (adv_en),
        .stall_i     (stall_i),
        .br_take_i   (br_take_i),
        .br_target_i (br_target_i),
        .pc_o        (pc_o),
        .pc_read_o   (pc_read_o)
    );

endmodule

// File: rtl/pc_unit_chk.sv
`timescale 1ns/1ps
module pc_unit_chk #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] COLD_TBASE = 32'h00C0_0000,
    parameter logic [ADDR_W-1:0] RST_VEC_OFS = '0
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              stall_i,
    input logic              br_take_i,
    input logic [ADDR_W-1:0] br_target_i,
    input logic              sr_wr_en_i,
    input logic              sr_wr_sel_i,
    input logic [ADDR_W-1:0] sr_wr_data_i,
    input logic              vec_rd_en_o,
    input logic [ADDR_W-1:0] vec_rd_addr_o,
    input logic [ADDR_W-1:0] vec_rd_data_i,
    input logic              run_ready_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] pc_read_o
);
    logic running;
    assign running = run_ready_o && rst_n;

    assert_cold_state_R1: assert property (@(posedge clk)
        !por_n |-> (vec_rd_en_o && !run_ready_o &&
                    vec_rd_addr_o == COLD_TBASE + RST_VEC_OFS));

    assert_seq_onehot_R2: assert property (@(posedge clk) disable iff (!por_n)
        !(vec_rd_en_o && run_ready_o));

    assert_vec_load_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(run_ready_o) |-> pc_o == {$past(vec_rd_data_i[ADDR_W-1:1]), 1'b0});

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!por_n)
        (running && !stall_i && !br_take_i) |=> pc_o == $past(pc_o) + ADDR_W'(2));

    assert_branch_R4: assert property (@(posedge clk) disable iff (!por_n)
        (running && !stall_i && br_take_i) |=> pc_o == {$past(br_target_i[ADDR_W-1:1]), 1'b0});

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (running && stall_i) |=> $stable(pc_o));

    assert_pc_even_R6: assert property (@(posedge clk) disable iff (!por_n)
        run_ready_o |-> !pc_o[0]);

    assert_read_stall_R7: assert property (@(posedge clk) disable iff (!por_n)
        (running && stall_i) |=> $stable(pc_read_o));

    assert_pc_wr_ignored_R8: assert property (@(posedge clk) disable iff (!por_n)
        (running && stall_i && sr_wr_en_i && sr_wr_sel_i) |=> $stable(pc_o));

    assert_tbase_write_R9: assert property (@(posedge clk) disable iff (!por_n)
        (sr_wr_en_i && !sr_wr_sel_i) |=>
            vec_rd_addr_o == {$past(sr_wr_data_i[ADDR_W-1:2]), 2'b00} + RST_VEC_OFS);

    assert_tbase_kept_R10: assert property (@(posedge clk) disable iff (!por_n)
        !(sr_wr_en_i && !sr_wr_sel_i) |=> $stable(vec_rd_addr_o));

endmodule

bind pc_unit pc_unit_chk #(
    .ADDR_W      (ADDR_W),
    .COLD_TBASE  (COLD_TBASE),
    .RST_VEC_OFS (RST_VEC_OFS)
) chk_i (.*);

// File: tb/pc_unit_tb_top.sv
`timescale 1ns/1ps
module pc_unit_tb_top;

    localparam logic [31:0] COLD = 32'h00C0_0000;

    logic        clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        por_n = 1'b1;
    logic        rst_n = 1'b1;
    logic        stall = 1'b0;
    logic        br = 1'b0;
    logic [31:0] tgt = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        vec_rd_en;
    logic [31:0] vec_rd_addr;
    logic [31:0] mem_q;
    logic        ready;
    logic [31:0] pc;
    logic [31:0] pc_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_pc;
    logic [31:0] exp_tb;

    pc_unit dut_i (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .stall_i       (stall),
        .br_take_i     (br),
        .br_target_i   (tgt),
        .sr_wr_en_i    (wr_en),
        .sr_wr_sel_i   (wr_sel),
        .sr_wr_data_i  (wr_data),
        .vec_rd_en_o   (vec_rd_en),
        .vec_rd_addr_o (vec_rd_addr),
        .vec_rd_data_i (mem_q),
        .run_ready_o   (ready),
        .pc_o          (pc),
        .pc_read_o     (pc_rd)
    );

    // vector memory contents: odd words so bit-0 clearing is visible
    function automatic logic [31:0] vec_word(input logic [31:0] a);
        return (a ^ 32'hA5A5_0000) + 32'h0000_1001;
    endfunction

    always @(posedge clk) begin
        if (vec_rd_en) mem_q <= vec_word(vec_rd_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // called on the falling edge right after reset release
    task automatic startup(input string req, input logic [31:0] base);
        chk({req, " rd_en"}, 32'(vec_rd_en), 32'd1);
        chk({req, " rd_addr"}, vec_rd_addr, base);
        tick();
        chk({req, " ready low"}, 32'(ready), 32'd0);
        tick();
        chk({req, " ready high"}, 32'(ready), 32'd1);
        exp_pc = {vec_word(base)};
        exp_pc[0] = 1'b0;
        chk({req, " pc loaded"}, pc, exp_pc);
    endtask

    // one running cycle with given stimulus, checked against the model
    task automatic cyc(input bit s, input bit b, input logic [31:0] t,
                       input bit we, input bit ws, input logic [31:0] wd);
        string req;
        stall = s; br = b; tgt = t; wr_en = we; wr_sel = ws; wr_data = wd;
        if (s)                req = "R5";
        else if (b)           req = "R4";
        else if (we && ws)    req = "R8";
        else                  req = "R3";
        if (!s) exp_pc = b ? {t[31:1], 1'b0} : exp_pc + 32'd2;
        if (we && !ws) exp_tb = {wd[31:2], 2'b00};
        tick();
        stall = 0; br = 0; wr_en = 0;
        chk(req, pc, exp_pc);
        chk("R7", pc_rd, exp_pc + 32'd2);
        chk("R6", 32'(pc[0]), 32'd0);
    endtask

    task automatic warm_reset();
        rst_n = 1'b0;
        tick();
        chk("R10 ready low", 32'(ready), 32'd0);
        rst_n = 1'b1;
        startup("R10", exp_tb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        exp_pc = '0;
        exp_tb = COLD;
        #1 por_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_en", 32'(vec_rd_en), 32'd1);
        chk("R1 addr", vec_rd_addr, COLD);
        chk("R1 ready", 32'(ready), 32'd0);
        por_n = 1'b1;
        startup("R2", COLD);

        // directed corners
        cyc(0, 0, '0, 0, 0, '0);                      // R3 plain step
        cyc(1, 1, 32'h1234_5679, 0, 0, '0);           // R5 stall beats branch
        cyc(0, 1, 32'h0000_4443, 0, 0, '0);           // R4 odd target
        cyc(0, 0, '0, 1, 1, 32'hDEAD_BEEF);           // R8 PC write dropped
        cyc(1, 0, '0, 1, 1, 32'h0000_0100);           // R8 while stalled
        cyc(0, 1, 32'hFFFF_FFFF, 0, 0, '0);           // R4 to top of space
        cyc(0, 0, '0, 0, 0, '0);                      // R3 wrap to 0
        chk("R3 wrap", pc, 32'h0);

        // R9: unaligned base write, then warm reset picks it up
        cyc(0, 0, '0, 1, 0, 32'h0001_2347);
        chk("R9 addr", vec_rd_addr, 32'h0001_2344);
        warm_reset();

        // constrained random running
        void'($urandom(32'd1234));
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 400; i++) begin
                cyc(($urandom % 4) == 0, ($urandom % 5) == 0, $urandom,
                    ($urandom % 3) == 0, $urandom % 2, $urandom);
            end
            warm_reset();   // R10 with whatever base random writes left
        end

        // cold reset after base change returns to the fixed base
        por_n = 1'b0;
        tick();
        chk("R1 cold again", vec_rd_addr, COLD);
        por_n = 1'b1;
        exp_tb = COLD;
        startup("R2", COLD);

        done = 1'b1;
        summary();
    end

endmodule